// File: doc/BRIEF.md
# Circular Processing-Element Reservation Allocator

This block keeps track of a ring of processing-element slots in a speculative multithreaded core. The oldest occupied slot is the head and the next free slot is the tail. A supertask asks for a contiguous group of slots, sized by the number of tasks on its most likely path. When the request is granted, the group begins at the tail and receives a group id. The supertask's start task occupies the first slot of the group at the moment of the grant. After that, a fill request places one more task into the next slot of a chosen group, at most once per cycle.

Groups leave the ring in program order. The group at the head is released only after every slot it reserved has been filled. Two kinds of squash are supported. A local squash empties one group back to its start task but keeps the group's reservation, so refilling can start on the next cycle. A global squash releases the named group and every group younger than it, and pulls the tail back to that group's first slot.

Top module: `pe_resv_ring`

## Requirements
- R1: After reset, free_cnt equals N_PE (12), active_cnt is 0, head_ptr and tail_ptr are 0, and no grant, fill or commit is reported. Whenever active_cnt is 0, free_cnt is N_PE and head_ptr equals tail_ptr.
- R2: A reserve request is granted in the same cycle when all of the following hold: no global squash is requested, the size is between 1 and N_PE/4 (3), the size does not exceed free_cnt, and fewer than N_GRP (4) groups are active. On a grant:
  - rsv_base is the current tail_ptr.
  - rsv_gid is the next group id in ring order 0, 1, 2, 3, 0 and so on.
  - From the next cycle, tail_ptr has advanced by the size modulo N_PE and free_cnt has dropped by the size.
- R3: A reserve request is refused, and changes no state, when any of these holds: the size is 0, the size is above N_PE/4, the size exceeds free_cnt, or N_GRP groups are already active.
- R4: A granted group starts with a fill count of one, which stands for its start task. A fill request to an active group whose fill count is below its size is accepted with fill_slot = (first slot + fill count) mod N_PE, and the count then rises by one.
- R5: A fill request is refused (fill_ok low) when the target group is already full or is not active.
- R6: A commit request retires the head group only if all of its slots are filled. On retirement:
  - head_ptr advances by the group size.
  - free_cnt rises by the group size.
  - active_cnt falls by one.
  - Commit and reserve may both succeed in the same cycle; the reserve is judged against the free count from before the commit.
  - Otherwise commit_ok stays low and nothing changes.
- R7: A local squash of an active group returns its fill count to one and keeps its slots. A fill to that same group in the squash cycle is refused. The next accepted fill reuses the group's second slot.
- R8: A global squash of an active group releases that group and all younger groups in one cycle:
  - tail_ptr is set to the group's first slot.
  - active_cnt becomes the number of older groups.
  - free_cnt is recomputed from head_ptr and the new tail.
  - Any reserve, fill or commit in that cycle is refused.
  - A global squash naming an inactive group changes nothing.
- R9: Slot numbers wrap modulo N_PE, both for group placement and for fill slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsv_req | input | 1 | Reserve a group |
| rsv_size | input | PW (4) | Number of slots requested |
| rsv_grant | output | 1 | Reserve accepted this cycle |
| rsv_gid | output | GW (2) | Id of the group being granted |
| rsv_base | output | PW (4) | First slot of the granted group |
| fill_req | input | 1 | Place one more task into a group |
| fill_gid | input | GW (2) | Group to fill |
| fill_ok | output | 1 | Fill accepted this cycle |
| fill_slot | output | PW (4) | Slot that receives the task |
| commit_req | input | 1 | Retire the head group |
| commit_ok | output | 1 | Head group retired this cycle |
| lsq_req | input | 1 | Local squash request |
| lsq_gid | input | GW (2) | Group to squash locally |
| gsq_req | input | 1 | Global squash request |
| gsq_gid | input | GW (2) | Oldest group to discard |
| free_cnt | output | CW (4) | Number of unreserved slots |
| active_cnt | output | AW (3) | Number of groups in flight |
| head_ptr | output | PW (4) | Oldest reserved slot |
| tail_ptr | output | PW (4) | Next free slot |

## Verification
The hardest situation to reach is a global squash in a ring that has already wrapped. In that case the discarded groups lie on both sides of slot zero, and the recomputed free count depends on the modulo distance from head to the new tail. The stimulus builds this up step by step:
- It fills the ring with four groups until the active limit refuses a fifth.
- It retires the oldest group and reserves again across the wrap point.
- It squashes a group's fill back to one and refills it.
- It then issues the global squash, so the released groups straddle slot zero.

Directed cases then put a local squash and a fill on the same group in one cycle, and pair a commit with a reserve in one cycle.

// File: rtl/pe_resv_pkg.sv
package pe_resv_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_RSV  = 3'd1,
    OP_FILL = 3'd2,
    OP_CMT  = 3'd3,
    OP_LSQ  = 3'd4,
    OP_GSQ  = 3'd5
  } prr_op_e;

  // a + b modulo m, with a and b already below m
  function automatic int ring_add(input int a, input int b, input int m);
    int s;
    s = a + b;
    return (s >= m) ? s - m : s;
  endfunction

  // forward distance from a to b on a ring of size m
  function automatic int ring_dist(input int a, input int b, input int m);
    return (b >= a) ? b - a : b + m - a;
  endfunction

endpackage

// File: rtl/prr_grp_slot.sv
module prr_grp_slot #(
  parameter int PW = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_base,
  input  logic [SW-1:0] load_size,
  input  logic          fill_inc,
  input  logic          fill_rst,
  output logic [PW-1:0] base_q,
  output logic [SW-1:0] size_q,
  output logic [SW-1:0] fill_q
);
  logic [PW-1:0] base_d;
  logic [SW-1:0] size_d, fill_d;
  logic          en;

  always_comb begin
    en     = load | fill_inc | fill_rst;
    base_d = base_q;
    size_d = size_q;
    fill_d = fill_q;
    if (load) begin
      base_d = load_base;
      size_d = load_size;
      fill_d = SW'(1);
    end else if (fill_rst) begin
      fill_d = SW'(1);
    end else if (fill_inc) begin
      fill_d = fill_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      fill_q <= '0;
    end else if (en) begin
      base_q <= base_d;
      size_q <= size_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/prr_ring_regs.sv
module prr_ring_regs #(
  parameter int N_PE = 12,
  parameter int PW   = 4,
  parameter int CW   = 4,
  parameter int AW   = 3,
  parameter int GW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] head_d,
  input  logic [PW-1:0] tail_d,
  input  logic [CW-1:0] free_d,
  input  logic [AW-1:0] act_d,
  input  logic [GW-1:0] gh_d,
  input  logic [GW-1:0] gt_d,
  output logic [PW-1:0] head_q,
  output logic [PW-1:0] tail_q,
  output logic [CW-1:0] free_q,
  output logic [AW-1:0] act_q,
  output logic [GW-1:0] gh_q,
  output logic [GW-1:0] gt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      free_q <= CW'(N_PE);
      act_q  <= '0;
      gh_q   <= '0;
      gt_q   <= '0;
    end else if (en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      free_q <= free_d;
      act_q  <= act_d;
      gh_q   <= gh_d;
      gt_q   <= gt_d;
    end
  end
endmodule

// File: rtl/pe_resv_ring.sv
module pe_resv_ring #(
  parameter int N_PE  = 12,
  parameter int N_GRP = 4,
  localparam int MAX_SZ = N_PE / N_GRP,
  localparam int PW = $clog2(N_PE),
  localparam int CW = $clog2(N_PE + 1),
  localparam int SW = $clog2(MAX_SZ + 1),
  localparam int GW = $clog2(N_GRP),
  localparam int AW = $clog2(N_GRP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rsv_req,
  input  logic [PW-1:0] rsv_size,
  output logic          rsv_grant,
  output logic [GW-1:0] rsv_gid,
  output logic [PW-1:0] rsv_base,
  input  logic          fill_req,
  input  logic [GW-1:0] fill_gid,
  output logic          fill_ok,
  output logic [PW-1:0] fill_slot,
  input  logic          commit_req,
  output logic          commit_ok,
  input  logic          lsq_req,
  input  logic [GW-1:0] lsq_gid,
  input  logic          gsq_req,
  input  logic [GW-1:0] gsq_gid,
  output logic [CW-1:0] free_cnt,
  output logic [AW-1:0] active_cnt,
  output logic [PW-1:0] head_ptr,
  output logic [PW-1:0] tail_ptr
);
  import pe_resv_pkg::*;

  logic [PW-1:0]    e_base [N_GRP];
  logic [SW-1:0]    e_size [N_GRP];
  logic [SW-1:0]    e_fill [N_GRP];
  logic [N_GRP-1:0] live;

  logic [PW-1:0] head_q, tail_q, head_d, tail_d;
  logic [CW-1:0] free_q, free_d;
  logic [AW-1:0] act_q, act_d;
  logic [GW-1:0] gh_q, gt_q, gh_d, gt_d;
  logic          lsq_hit, gsq_hit, upd;

  // per-group records and liveness (group i is live if it lies within act_q of the group head)
  for (genvar i = 0; i < N_GRP; i++) begin : g_grp
    assign live[i] = ring_dist(int'(gh_q), i, N_GRP) < int'(act_q);

    prr_grp_slot #(.PW(PW), .SW(SW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rsv_grant && (int'(gt_q) == i)),
      .load_base (tail_q),
      .load_size (SW'(rsv_size)),
      .fill_inc  (fill_ok && (int'(fill_gid) == i)),
      .fill_rst  (lsq_hit && (int'(lsq_gid) == i)),
      .base_q    (e_base[i]),
      .size_q    (e_size[i]),
      .fill_q    (e_fill[i])
    );
  end

  // request decode
  always_comb begin
    rsv_grant = rsv_req && !gsq_req && (rsv_size != '0)
                && (int'(rsv_size) <= MAX_SZ)
                && (int'(rsv_size) <= int'(free_q))
                && (int'(act_q) < N_GRP);
    commit_ok = commit_req && !gsq_req && (act_q != '0)
                && (e_fill[gh_q] == e_size[gh_q]);
    lsq_hit   = lsq_req && !gsq_req && live[lsq_gid];
    fill_ok   = fill_req && !gsq_req && live[fill_gid]
                && (e_fill[fill_gid] < e_size[fill_gid])
                && !(lsq_hit && (lsq_gid == fill_gid));
    gsq_hit   = gsq_req && live[gsq_gid];
    rsv_gid   = gt_q;
    rsv_base  = tail_q;
    fill_slot = PW'(ring_add(int'(e_base[fill_gid]), int'(e_fill[fill_gid]), N_PE));
  end

  // ring next state
  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    free_d = free_q;
    act_d  = act_q;
    gh_d   = gh_q;
    gt_d   = gt_q;
    upd    = gsq_hit || rsv_grant || commit_ok;
    if (gsq_hit) begin
      tail_d = e_base[gsq_gid];
      gt_d   = gsq_gid;
      act_d  = AW'(ring_dist(int'(gh_q), int'(gsq_gid), N_GRP));
      free_d = CW'(N_PE - ring_dist(int'(head_q), int'(e_base[gsq_gid]), N_PE));
    end else begin
      if (rsv_grant) begin
        tail_d = PW'(ring_add(int'(tail_q), int'(rsv_size), N_PE));
        gt_d   = GW'(ring_add(int'(gt_q), 1, N_GRP));
      end
      if (commit_ok) begin
        head_d = PW'(ring_add(int'(head_q), int'(e_size[gh_q]), N_PE));
        gh_d   = GW'(ring_add(int'(gh_q), 1, N_GRP));
      end
      act_d  = AW'(int'(act_q) + int'(rsv_grant) - int'(commit_ok));
      free_d = CW'(int'(free_q)
                   - (rsv_grant ? int'(rsv_size) : 0)
                   + (commit_ok ? int'(e_size[gh_q]) : 0));
    end
  end

  prr_ring_regs #(.N_PE(N_PE), .PW(PW), .CW(CW), .AW(AW), .GW(GW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (upd),
    .head_d (head_d),
    .tail_d (tail_d),
    .free_d (free_d),
    .act_d  (act_d),
    .gh_d   (gh_d),
    .gt_d   (gt_d),
    .head_q (head_q),
    .tail_q (tail_q),
    .free_q (free_q),
    .act_q  (act_q),
    .gh_q   (gh_q),
    .gt_q   (gt_q)
  );

  assign free_cnt   = free_q;
  assign active_cnt = act_q;
  assign head_ptr   = head_q;
  assign tail_ptr   = tail_q;
endmodule

// File: rtl/prr_checker.sv
module prr_checker #(
  parameter int N_PE  = 12,
  parameter int N_GRP = 4,
  localparam int MAX_SZ = N_PE / N_GRP,
  localparam int PW = $clog2(N_PE),
  localparam int CW = $clog2(N_PE + 1),
  localparam int AW = $clog2(N_GRP + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] rsv_size,
  input logic          rsv_grant,
  input logic          fill_ok,
  input logic [PW-1:0] fill_slot,
  input logic          commit_ok,
  input logic          gsq_req,
  input logic [CW-1:0] free_cnt,
  input logic [AW-1:0] active_cnt,
  input logic [PW-1:0] head_ptr,
  input logic [PW-1:0] tail_ptr
);
  import pe_resv_pkg::*;

  a_r1_empty_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (active_cnt == '0) |-> (int'(free_cnt) == N_PE && head_ptr == tail_ptr));

  a_r2_free_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_grant && !commit_ok) |=>
      (int'(free_cnt) == int'($past(free_cnt)) - int'($past(rsv_size))));

  a_r2_tail_move: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_grant |=>
      (int'(tail_ptr) == ring_add(int'($past(tail_ptr)), int'($past(rsv_size)), N_PE)));

  a_r3_grant_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_grant |-> (rsv_size != '0 && int'(rsv_size) <= MAX_SZ
                   && rsv_size <= PW'(free_cnt) && int'(active_cnt) < N_GRP));

  a_r6_commit_count: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |=>
      (int'(active_cnt) == int'($past(active_cnt)) - 1 + int'($past(rsv_grant))));

  a_r8_gsq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    gsq_req |-> (!rsv_grant && !fill_ok && !commit_ok));

  a_r9_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok |-> (int'(fill_slot) < N_PE));
endmodule

bind pe_resv_ring prr_checker #(.N_PE(N_PE), .N_GRP(N_GRP)) u_prr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rsv_size   (rsv_size),
  .rsv_grant  (rsv_grant),
  .fill_ok    (fill_ok),
  .fill_slot  (fill_slot),
  .commit_ok  (commit_ok),
  .gsq_req    (gsq_req),
  .free_cnt   (free_cnt),
  .active_cnt (active_cnt),
  .head_ptr   (head_ptr),
  .tail_ptr   (tail_ptr)
);

// File: tb/pe_resv_ring_bench.sv
module pe_resv_ring_bench;
  import pe_resv_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rsv_req, fill_req, commit_req, lsq_req, gsq_req;
  logic [3:0] rsv_size;
  logic [1:0] fill_gid, lsq_gid, gsq_gid;
  logic       rsv_grant, fill_ok, commit_ok;
  logic [1:0] rsv_gid;
  logic [3:0] rsv_base, fill_slot, free_cnt, head_ptr, tail_ptr;
  logic [2:0] active_cnt;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #10 clk = ~clk;

  pe_resv_ring u_pe_resv_ring (
    .clk(clk), .rst_n(rst_n),
    .rsv_req(rsv_req), .rsv_size(rsv_size), .rsv_grant(rsv_grant),
    .rsv_gid(rsv_gid), .rsv_base(rsv_base),
    .fill_req(fill_req), .fill_gid(fill_gid), .fill_ok(fill_ok), .fill_slot(fill_slot),
    .commit_req(commit_req), .commit_ok(commit_ok),
    .lsq_req(lsq_req), .lsq_gid(lsq_gid), .gsq_req(gsq_req), .gsq_gid(gsq_gid),
    .free_cnt(free_cnt), .active_cnt(active_cnt), .head_ptr(head_ptr), .tail_ptr(tail_ptr)
  );

  // {req, op, arg, exp_ok, exp_val, exp_free, exp_act}
  localparam int NV = 26;
  localparam logic [22:0] VEC [NV] = '{
    {4'd2, OP_RSV,  4'd3, 1'b1, 4'd0,  4'd9,  3'd1}, // R2 g0 at 0
    {4'd2, OP_RSV,  4'd2, 1'b1, 4'd3,  4'd7,  3'd2}, // R2 g1 at 3
    {4'd4, OP_FILL, 4'd0, 1'b1, 4'd1,  4'd7,  3'd2}, // R4
    {4'd4, OP_FILL, 4'd0, 1'b1, 4'd2,  4'd7,  3'd2}, // R4
    {4'd5, OP_FILL, 4'd0, 1'b0, 4'd0,  4'd7,  3'd2}, // R5 full
    {4'd2, OP_RSV,  4'd3, 1'b1, 4'd5,  4'd4,  3'd3}, // R2 g2
    {4'd2, OP_RSV,  4'd3, 1'b1, 4'd8,  4'd1,  3'd4}, // R2 g3
    {4'd3, OP_RSV,  4'd1, 1'b0, 4'd0,  4'd1,  3'd4}, // R3 group limit
    {4'd6, OP_CMT,  4'd0, 1'b1, 4'd0,  4'd4,  3'd3}, // R6 retire g0
    {4'd3, OP_RSV,  4'd4, 1'b0, 4'd0,  4'd4,  3'd3}, // R3 too large
    {4'd9, OP_RSV,  4'd3, 1'b1, 4'd11, 4'd1,  3'd4}, // R9 wraps
    {4'd6, OP_CMT,  4'd0, 1'b0, 4'd0,  4'd1,  3'd4}, // R6 g1 not full
    {4'd4, OP_FILL, 4'd1, 1'b1, 4'd4,  4'd1,  3'd4}, // R4
    {4'd7, OP_LSQ,  4'd1, 1'b0, 4'd0,  4'd1,  3'd4}, // R7
    {4'd7, OP_CMT,  4'd0, 1'b0, 4'd0,  4'd1,  3'd4}, // R7 back to one
    {4'd7, OP_FILL, 4'd1, 1'b1, 4'd4,  4'd1,  3'd4}, // R7 refill
    {4'd6, OP_CMT,  4'd0, 1'b1, 4'd0,  4'd3,  3'd3}, // R6
    {4'd9, OP_FILL, 4'd0, 1'b1, 4'd0,  4'd3,  3'd3}, // R9 slot 0
    {4'd8, OP_GSQ,  4'd3, 1'b0, 4'd0,  4'd9,  3'd1}, // R8 drop g3,g0
    {4'd2, OP_RSV,  4'd2, 1'b1, 4'd8,  4'd7,  3'd2}, // R2
    {4'd4, OP_FILL, 4'd2, 1'b1, 4'd6,  4'd7,  3'd2}, // R4
    {4'd4, OP_FILL, 4'd2, 1'b1, 4'd7,  4'd7,  3'd2}, // R4
    {4'd6, OP_CMT,  4'd0, 1'b1, 4'd0,  4'd10, 3'd1}, // R6
    {4'd8, OP_GSQ,  4'd3, 1'b0, 4'd0,  4'd12, 3'd0}, // R8 head group
    {4'd6, OP_CMT,  4'd0, 1'b0, 4'd0,  4'd12, 3'd0}, // R6 empty
    {4'd5, OP_FILL, 4'd1, 1'b0, 4'd0,  4'd12, 3'd0}  // R5 inactive
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    rsv_req = 0; fill_req = 0; commit_req = 0; lsq_req = 0; gsq_req = 0;
    rsv_size = 0; fill_gid = 0; lsq_gid = 0; gsq_gid = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "free", free_cnt, 12);
    chk("R1", "active", active_cnt, 0);
    chk("R1", "head", head_ptr, 0);
    chk("R1", "tail", tail_ptr, 0);

    for (int v = 0; v < NV; v++) begin
      logic [22:0] e;
      string rq;
      prr_op_e op;
      e  = VEC[v];
      rq = $sformatf("R%0d", e[22:19]);
      op = prr_op_e'(e[18:16]);
      idle_inputs();
      case (op)
        OP_RSV:  begin rsv_req = 1; rsv_size = e[15:12]; end
        OP_FILL: begin fill_req = 1; fill_gid = e[13:12]; end
        OP_CMT:  commit_req = 1;
        OP_LSQ:  begin lsq_req = 1; lsq_gid = e[13:12]; end
        OP_GSQ:  begin gsq_req = 1; gsq_gid = e[13:12]; end
        default: ;
      endcase
      #5;
      case (op)
        OP_RSV: begin
          chk(rq, "grant", rsv_grant, e[11]);
          if (e[11]) chk(rq, "base", rsv_base, e[10:7]);
        end
        OP_FILL: begin
          chk(rq, "fill_ok", fill_ok, e[11]);
          if (e[11]) chk(rq, "slot", fill_slot, e[10:7]);
        end
        OP_CMT:  chk(rq, "commit_ok", commit_ok, e[11]);
        default: ;
      endcase
      @(negedge clk);
      chk(rq, "free", free_cnt, e[6:3]);
      chk(rq, "active", active_cnt, e[2:0]);
    end

    // reset mid-run restores R1 state
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "free after reset", free_cnt, 12);
    chk("R1", "active after reset", active_cnt, 0);
    chk("R1", "tail after reset", tail_ptr, 0);
    #5 chk("R1", "idle grant", rsv_grant, 0);
    @(negedge clk);

    // R3: size 0 refused
    rsv_req = 1; rsv_size = 0;
    #5 chk("R3", "size0 grant", rsv_grant, 0);
    @(negedge clk);
    chk("R3", "size0 free", free_cnt, 12);

    // R2: first grant gives group 0 at slot 0
    rsv_size = 2;
    #5 chk("R2", "gid", rsv_gid, 0);
    chk("R2", "grant", rsv_grant, 1);
    @(negedge clk);
    idle_inputs();

    // R8: squash naming an inactive group changes nothing
    gsq_req = 1; gsq_gid = 1;
    @(negedge clk);
    idle_inputs();
    chk("R8", "inactive gsq free", free_cnt, 10);
    chk("R8", "inactive gsq active", active_cnt, 1);

    // R7: fill and local squash on the same group in one cycle
    fill_req = 1; fill_gid = 0; lsq_req = 1; lsq_gid = 0;
    #5 chk("R7", "fill during lsq", fill_ok, 0);
    @(negedge clk);
    idle_inputs();
    fill_req = 1; fill_gid = 0;
    #5 chk("R7", "fill after lsq", fill_ok, 1);
    chk("R7", "slot after lsq", fill_slot, 1);
    @(negedge clk);
    idle_inputs();

    // R6: commit and reserve in the same cycle
    commit_req = 1; rsv_req = 1; rsv_size = 3;
    #5 chk("R6", "commit_ok", commit_ok, 1);
    chk("R6", "grant with commit", rsv_grant, 1);
    chk("R6", "base with commit", rsv_base, 2);
    chk("R6", "gid with commit", rsv_gid, 1);
    @(negedge clk);
    idle_inputs();
    chk("R6", "free", free_cnt, 9);
    chk("R6", "active", active_cnt, 1);
    chk("R6", "head", head_ptr, 2);
    chk("R6", "tail", tail_ptr, 5);

    done = 1;
    summary();
    $finish;
  end
endmodule